// File: doc/BRIEF.md
# Receive Frame Status Queue

This block sits beside a synchronous bit-oriented receiver that hands frame payload to a DMA engine. The DMA engine drains the byte data without knowing where one frame ends and the next begins. This block counts the bytes of the frame in progress. Each time the receiver signals a frame end, it stores that count together with the frame's closing status flags as one queue entry. Software can then read the outcome of several back-to-back frames well after their data has gone, one entry per read. The block is separate from the receive data FIFO and does not touch it.

When the queue function is switched off, nothing is stored. Each frame end's status flags are shown directly at the read port in place of the queue head, with a zero count. A sticky flag records any frame end that found the queue full and had to be discarded.

Top module: `sdlc_frame_status_queue`

## Requirements
- R1: The queue holds up to 10 entries of 19 bits each. Bits 18:14 of an entry carry the frame status input unchanged: bit 18 is end-of-frame, bit 17 is CRC error, bit 16 is receive overrun, and bits 15:14 are the residue code. Bits 13:0 carry the byte count of that frame.
- R2: The 14-bit byte counter adds one for each cycle in which the byte strobe is high. It returns to zero after every frame end. A byte strobe in the same cycle as a frame end belongs to the frame that is ending, and a frame with no bytes records a count of 0.
- R3: The byte counter saturates at 16383 and does not wrap.
- R4: While enabled, every accepted frame end appends one entry. The read port shows the oldest entry, and the valid flag rises in the cycle after the first push.
- R5: A pop strobe removes the oldest entry. The next entry, or a low valid flag, is visible in the following cycle. A pop while the queue is empty has no effect.
- R6: A frame end that arrives while all 10 entries are occupied, with no pop in the same cycle, is discarded. The stored entries are unchanged and the overflow flag is set.
- R7: A frame end and a pop in the same cycle on a full queue are both carried out, and the new entry becomes the last one.
- R8: The overflow flag stays set until the clear input is pulsed. A discard in the same cycle as a clear leaves the flag set.
- R9: While the enable input is low, the queue is empty and the byte counter reads 0. Nothing stored before disabling is visible after enabling again.
- R10: While disabled, a frame end shows its status flags at the read port with count bits 13:0 equal to 0, and valid goes high. The shown value stays until a pop clears valid or a later frame end replaces it.
- R11: After reset, valid and the overflow flag are low and the byte counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsq_enable | input | 1 | Enables queuing; low flushes and selects direct status |
| rx_byte_stb | input | 1 | One received payload byte this cycle |
| rx_frame_end | input | 1 | Closing flag of a frame seen this cycle |
| rx_status | input | 5 | Status flags of the ending frame (layout in R1) |
| st_pop | input | 1 | Status read strobe, removes the shown entry |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| st_valid | output | 1 | Read port holds a valid entry |
| st_entry | output | 19 | Oldest entry, or direct status while disabled |
| ovf_flag | output | 1 | Sticky discarded-frame flag |
| cur_count | output | 14 | Byte count of the frame in progress |

## Verification
Every registered result (queue contents, byte counter, overflow flag, direct status) is due exactly one clock edge after the strobe that causes it. The read-port selection follows the enable input in the same cycle. The bench drives inputs on the falling edge and moves its behavioural model forward by one edge at the same moment. On the next falling edge it compares all four outputs against the model, so every check samples half a period after the edge that produced the value. The entry bits are compared only while valid is high, because their value is undefined otherwise.

// File: rtl/fsq_pkg.sv
// Shared definitions for the receive frame status queue.
// Assumes the status word layout is fixed by the receiver that feeds it.
package fsq_pkg;
    localparam int STAT_W = 5;

    // Status flags presented with each frame end (MSB first in the entry)
    typedef struct packed {
        logic       eof;
        logic       crc_err;
        logic       overrun;
        logic [1:0] residue;
    } rx_status_t;

    // Saturating increment of an unsigned value limited to max_val
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] max_val);
        return (v >= max_val) ? max_val : v + 32'd1;
    endfunction
endpackage

// File: rtl/fsq_byte_counter.sv
// Counts payload bytes of the frame in progress, saturating at all-ones.
// Assumes a byte strobe coincident with a frame end belongs to that frame.
// count_incl is the count including the current cycle's byte, for capture.
module fsq_byte_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             byte_stb,
    input  logic             frame_end,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_incl
);
    import fsq_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count including this cycle's byte, held at the ceiling
    always_comb begin
        if (byte_stb)
            count_incl = CNT_W'(sat_inc(32'(count), 32'(CNT_MAX)));
        else
            count_incl = count;
    end

    // Register the running count, zeroing at reset, disable and frame end
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (frame_end)
            count <= '0;
        else
            count <= count_incl;
    end

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && byte_stb && !frame_end && !clear) |=> (count == CNT_MAX));
endmodule

// File: rtl/fsq_ring.sv
// Circular status store with occupancy tracking.
// Assumes push and pop requests are already qualified by the enable.
// A push on a full ring is accepted only when a pop frees a slot that cycle.
module fsq_ring #(
    parameter int W     = 19,
    parameter int DEPTH = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push_req,
    input  logic         pop_req,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] level;
    logic             pop_ok, push_ok;

    // Qualify requests against occupancy
    always_comb begin
        pop_ok  = pop_req && (level != '0);
        push_ok = push_req && ((level != FULL) || pop_ok);
        drop    = push_req && !push_ok;
    end

    // Write accepted entries into storage
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (level != '0);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);
    p_drop_keeps_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !flush) |=> (level == $past(level)));
    p_pop_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push_req && !flush) |=> (level == $past(level) - LVL_W'(1)));
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
endmodule

// File: rtl/fsq_direct.sv
// Holds the most recent frame-end word while queuing is switched off.
// Assumes 'active' is low whenever the queue path owns the read port.
module fsq_direct #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         capture,
    input  logic         release_stb,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic [W-1:0] word
);
    // Capture on frame end, drop on read, idle while queuing
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (capture) begin
            valid <= 1'b1;
            word  <= din;
        end else if (release_stb) begin
            valid <= 1'b0;
        end
    end

    p_capture_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && capture) |=> (valid && active) || !active);
endmodule

// File: rtl/sdlc_frame_status_queue.sv
// Receive frame status queue: counts payload bytes per frame and, at each
// frame end, stores {status flags, byte count} for later reads by software.
// Assumes the receiver raises rx_frame_end once per closing flag, with the
// final status on rx_status in that cycle. Disabling flushes all state except
// the sticky overflow flag and routes frame-end status directly to the port.
module sdlc_frame_status_queue #(
    parameter int CNT_W = 14,
    parameter int DEPTH = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                fsq_enable,
    input  logic                                rx_byte_stb,
    input  logic                                rx_frame_end,
    input  logic [fsq_pkg::STAT_W-1:0]          rx_status,
    input  logic                                st_pop,
    input  logic                                ovf_clear,
    output logic                                st_valid,
    output logic [fsq_pkg::STAT_W+CNT_W-1:0]    st_entry,
    output logic                                ovf_flag,
    output logic [CNT_W-1:0]                    cur_count
);
    import fsq_pkg::*;

    localparam int ENTRY_W = STAT_W + CNT_W;

    rx_status_t         stat_s;
    logic [CNT_W-1:0]   count_incl;
    logic [ENTRY_W-1:0] new_entry, ring_head, direct_word;
    logic               ring_ne, ring_drop, direct_valid;
    logic               push_req, pop_req;

    // Form the entry and qualify strobes with the enable
    always_comb begin
        stat_s    = rx_status_t'(rx_status);
        new_entry = {stat_s, count_incl};
        push_req  = fsq_enable && rx_frame_end;
        pop_req   = fsq_enable && st_pop;
    end

    fsq_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!fsq_enable),
        .byte_stb   (rx_byte_stb),
        .frame_end  (rx_frame_end),
        .count      (cur_count),
        .count_incl (count_incl)
    );

    fsq_ring #(.W(ENTRY_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!fsq_enable),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .din       (new_entry),
        .head      (ring_head),
        .not_empty (ring_ne),
        .drop      (ring_drop)
    );

    fsq_direct #(.W(ENTRY_W)) u_direct (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (!fsq_enable),
        .capture     (rx_frame_end),
        .release_stb (st_pop),
        .din         ({stat_s, {CNT_W{1'b0}}}),
        .valid       (direct_valid),
        .word        (direct_word)
    );

    // Sticky overflow: a discard wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (ring_drop)
            ovf_flag <= 1'b1;
        else if (ovf_clear)
            ovf_flag <= 1'b0;
    end

    // Select the read port source
    always_comb begin
        if (fsq_enable) begin
            st_valid = ring_ne;
            st_entry = ring_head;
        end else begin
            st_valid = direct_valid;
            st_entry = direct_word;
        end
    end

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clear) |=> ovf_flag);
    p_drop_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_drop |=> ovf_flag);
    p_count_zero_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fsq_enable |=> (cur_count == '0));
endmodule

// File: tb/sim_sdlc_frame_status_queue.sv
// Bench: behavioural reference model stepped on each falling edge.
module sim_sdlc_frame_status_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, bstb = 1'b0, fend = 1'b0, pop = 1'b0, clr = 1'b0;
    logic [4:0]  st = '0;
    logic        v, ovf;
    logic [18:0] ent;
    logic [13:0] cnt;

    int compared = 0, mismatched = 0;
    bit done = 0;

    int q[$];
    int m_cnt = 0, m_dent = 0;
    bit m_ovf = 0, m_dval = 0, m_en = 0;

    always #4 clk = ~clk;

    sdlc_frame_status_queue u0 (
        .clk(clk), .rst_n(rst_n), .fsq_enable(en), .rx_byte_stb(bstb),
        .rx_frame_end(fend), .rx_status(st), .st_pop(pop), .ovf_clear(clr),
        .st_valid(v), .st_entry(ent), .ovf_flag(ovf), .cur_count(cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs, drive new inputs, advance the model
    task automatic step(input bit r, input bit e, input bit b, input bit f,
                        input logic [4:0] s, input bit p, input bit c);
        bit exp_v;
        int exp_e, incl;
        bit pop_ok, set_ovf;
        @(negedge clk);
        exp_v = m_en ? (q.size() > 0) : m_dval;
        exp_e = m_en ? ((q.size() > 0) ? q[0] : 0) : m_dent;
        chk("R5 valid", int'(v), int'(exp_v));
        if (exp_v) chk("R1 entry", int'(ent), exp_e);
        chk("R8 overflow", int'(ovf), int'(m_ovf));
        chk("R2 count", int'(cnt), m_cnt);
        rst_n = r; en = e; bstb = b; fend = f; st = s; pop = p; clr = c;
        m_en = e;
        set_ovf = 0;
        if (!r) begin
            q.delete(); m_cnt = 0; m_ovf = 0; m_dval = 0; m_dent = 0;
        end else begin
            if (!e) begin
                q.delete(); m_cnt = 0;
                if (f) begin m_dval = 1; m_dent = int'(s) << 14; end
                else if (p) m_dval = 0;
            end else begin
                m_dval = 0; m_dent = 0;
                incl = b ? ((m_cnt >= 16383) ? 16383 : m_cnt + 1) : m_cnt;
                pop_ok = p && (q.size() > 0);
                if (f && q.size() == 10 && !pop_ok) set_ovf = 1;
                if (pop_ok) void'(q.pop_front());
                if (f && !set_ovf) q.push_back((int'(s) << 14) | incl);
                m_cnt = f ? 0 : incl;
            end
            m_ovf = set_ovf ? 1'b1 : (m_ovf && !c);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, en, 0, 0, 5'd0, 0, 0);
    endtask

    initial begin
        // R11: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 5'd0, 0, 0);
        step(1, 1, 0, 0, 5'd0, 0, 0);
        // R2 R4: frame of six bytes, last byte with the frame end
        for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 5'd0, 0, 0);
        step(1, 1, 1, 1, 5'b10000, 0, 0);
        // R2: zero-length frame, then a frame with gaps
        step(1, 1, 0, 1, 5'b11011, 0, 0);
        for (int i = 0; i < 7; i++) step(1, 1, i[0], 0, 5'd0, 0, 0);
        step(1, 1, 0, 1, 5'b10110, 0, 0);
        idle(2);
        // R5: drain, then pop on empty
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 5'd0, 1, 0);
        idle(2);
        // R6: fill ten, eleventh discarded
        for (int i = 0; i < 11; i++) begin
            step(1, 1, 1, 0, 5'd0, 0, 0);
            step(1, 1, 0, 1, 5'(i + 16), 0, 0);
        end
        idle(1);
        // R7: push and pop together when full
        step(1, 1, 1, 1, 5'b10101, 1, 0);
        // R8: discard with clear, flag stays; then clear alone
        step(1, 1, 0, 1, 5'b10001, 0, 1);
        idle(2);
        step(1, 1, 0, 0, 5'd0, 0, 1);
        idle(2);
        for (int i = 0; i < 11; i++) step(1, 1, 0, 0, 5'd0, 1, 0);
        // R3: counter saturation
        for (int i = 0; i < 16400; i++) step(1, 1, 1, 0, 5'd0, 0, 0);
        step(1, 1, 1, 1, 5'b10000, 0, 0);
        idle(2);
        step(1, 1, 1, 0, 5'd0, 0, 0);
        step(1, 1, 1, 0, 5'd0, 0, 0);
        // R9: disable flushes queue and counter
        step(1, 0, 1, 0, 5'd0, 0, 0);
        idle(2);
        // R10: direct status while disabled
        step(1, 0, 1, 1, 5'b11100, 0, 0);
        idle(2);
        step(1, 0, 0, 1, 5'b10011, 0, 0);
        idle(1);
        step(1, 0, 0, 0, 5'd0, 1, 0);
        idle(2);
        step(1, 1, 0, 0, 5'd0, 0, 0);
        idle(2);
        // Mixed traffic across all requirements
        for (int i = 0; i < 3000; i++)
            step(1, ($urandom_range(0, 99) > 3), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 5) == 0, 5'($urandom()),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 40) == 0);
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule